// File: doc/BRIEF.md
# Crossing-Synchronous Multi-Hit Strip Encoder

This block compresses the hit map of a pixel array that is organised as virtual strips. There are 128 strips. Each strip has 32 pixels, and the pixel that fired is reported as a 5-bit position code along the strip. On every crossing strobe the block captures the full strip hit vector and the per-strip position codes. It then uses the fast clock to pick out up to eight hit strips, taking the lowest strip numbers first.

The selected hits leave on a word stream that never pauses. Each crossing period has eight fast-clock cycles, which gives eight word slots. Every slot carries one word, valid or empty. The words of a crossing appear at a fixed distance of two crossing periods after capture, so a receiver can tie every word to its crossing without any handshake. An overflow flag marks a crossing in which more than eight strips fired and hits were dropped.

The crossing strobe is a one-cycle pulse that arrives every eighth fast-clock cycle. Reset is synchronous and active high.

Top module: `strip_hit_encoder`

## Requirements
- R1: Strip flags and position codes are sampled only on a clock edge where `bx_strobe` is high. Changes on `hit_in` or `z_in` in the other seven cycles of a crossing do not affect any output.
- R2: Let S be the edge where crossing N is sampled. The words for crossing N are driven on `word_o` just after the edges 16+k cycles after S, for slot k = 0..7. This is the strobe edge of crossing N+2 and the seven edges that follow it.
- R3: Hit strips are placed in slots in ascending strip-number order, starting at slot 0. When more than eight strips fired, the eight lowest-numbered ones are sent.
- R4: Word layout: bit 12 is the valid flag, bits 11:5 are the strip number (0..127), and bits 4:0 are the position code that was captured for that strip. Strips 0 and 127 are reported like any other strip.
- R5: A crossing with H hits fills slots 0..H-1 with valid words. Every remaining slot carries the all-zero word (valid 0, payload 0).
- R6: `overflow_o` is high during all eight slots of a crossing's output when more than eight strips fired in that crossing, and low otherwise. It changes only on a strobe edge.
- R7: While reset is applied, and for the first two crossings after it, `word_o` and `overflow_o` are zero.
- R8: Exactly eight hit strips fill all eight slots with `overflow_o` low. Nine hit strips also fill all eight slots and raise `overflow_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, eight cycles per crossing |
| rst | input | 1 | Synchronous active-high reset |
| bx_strobe | input | 1 | One-cycle crossing pulse, every eighth cycle |
| hit_in | input | 128 | Per-strip hit flag, bit i = strip i |
| z_in | input | 640 | Per-strip position code, strip i at bits 5i+4:5i |
| word_o | output | 13 | Slot word: valid, strip number, position code |
| overflow_o | output | 1 | More than eight hits in the crossing now being sent |

## Verification
The bench first walks a table of hit maps that separate the selection rules from one another:
- An empty map and single hits at strip 0, strip 64 and strip 127 show the slot-0 placement and the extremes of the strip field.
- Exactly eight and exactly nine sparse hits tell the full-but-clean case apart from the first overflow.
- An all-ones map, alternating-bit maps and a 20-strip cluster near the top show that the lowest strips win and that the order within the crossing is ascending.

Many crossings with 0 to 20 random hits then check that results are not carried over between back-to-back crossings. In every non-strobe cycle the bench also drives random data on the inputs. This makes sure that a design sampling outside the strobe produces wrong words. A reset in the middle of the stream checks that older crossings are flushed.

// File: rtl/strip_enc_pkg.sv
`timescale 1ns/1ps
package strip_enc_pkg;

    localparam int unsigned NSTRIP = 128;
    localparam int unsigned ZW     = 5;
    localparam int unsigned MAXHIT = 8;

    localparam int unsigned SIW   = $clog2(NSTRIP);
    localparam int unsigned WORDW = 1 + SIW + ZW;
    localparam int unsigned CNTW  = $clog2(MAXHIT + 1);
    localparam int unsigned SLW   = $clog2(MAXHIT);
    localparam int unsigned ZVECW = NSTRIP * ZW;

    typedef struct packed {
        logic           valid;
        logic [SIW-1:0] strip;
        logic [ZW-1:0]  z;
    } hit_word_t;

    function automatic hit_word_t make_word(input logic v,
                                            input logic [SIW-1:0] s,
                                            input logic [ZW-1:0] z);
        hit_word_t w;
        w = '0;
        if (v) begin
            w.valid = 1'b1;
            w.strip = s;
            w.z     = z;
        end
        return w;
    endfunction

endpackage

// File: rtl/sf_prio_find.sv
`timescale 1ns/1ps
module sf_prio_find #(
    parameter int unsigned W  = 128,
    parameter int unsigned IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx,
    output logic [W-1:0]  onehot
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end

    assign onehot = found ? (W'(1) << idx) : '0;
endmodule

// File: rtl/sf_hit_scanner.sv
`timescale 1ns/1ps
module sf_hit_scanner
    import strip_enc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               strobe,
    input  logic [NSTRIP-1:0]  hit_in,
    input  logic [ZVECW-1:0]   z_in,
    output hit_word_t          res_o [MAXHIT],
    output logic               left_o
);
    logic [NSTRIP-1:0] mask_q;
    logic [ZVECW-1:0]  zsnap_q;
    logic [CNTW-1:0]   cnt_q;
    hit_word_t         res_q [MAXHIT];

    logic [NSTRIP-1:0] src;
    logic [ZVECW-1:0]  zsrc;
    logic              pfound;
    logic [SIW-1:0]    pidx;
    logic [NSTRIP-1:0] ponehot;
    hit_word_t         pick;

    // on the strobe edge the first pick is taken straight from the inputs
    assign src  = strobe ? hit_in : mask_q;
    assign zsrc = strobe ? z_in   : zsnap_q;

    sf_prio_find #(.W(NSTRIP), .IW(SIW)) u_find (
        .vec    (src),
        .found  (pfound),
        .idx    (pidx),
        .onehot (ponehot)
    );

    assign pick = make_word(pfound, pidx, zsrc[pidx*ZW +: ZW]);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q  <= '0;
            zsnap_q <= '0;
            cnt_q   <= '0;
            for (int k = 0; k < MAXHIT; k++) res_q[k] <= '0;
        end else if (strobe) begin
            mask_q   <= hit_in & ~ponehot;
            zsnap_q  <= z_in;
            cnt_q    <= CNTW'(1);
            res_q[0] <= pick;
            for (int k = 1; k < MAXHIT; k++) res_q[k] <= '0;
        end else if (cnt_q < CNTW'(MAXHIT)) begin
            res_q[cnt_q[SLW-1:0]] <= pick;
            mask_q <= mask_q & ~ponehot;
            cnt_q  <= cnt_q + CNTW'(1);
        end
    end

    assign res_o  = res_q;
    assign left_o = |mask_q;
endmodule

// File: rtl/sf_slot_stream.sv
`timescale 1ns/1ps
module sf_slot_stream
    import strip_enc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      strobe,
    input  hit_word_t res_i [MAXHIT],
    input  logic      left_i,
    output hit_word_t word_o,
    output logic      ovf_o
);
    hit_word_t       done_q [MAXHIT];
    logic            done_ovf_q;
    hit_word_t       tx_q [MAXHIT];
    logic [CNTW-1:0] slot_q;
    hit_word_t       word_q;
    logic            ovf_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < MAXHIT; k++) begin
                done_q[k] <= '0;
                tx_q[k]   <= '0;
            end
            done_ovf_q <= 1'b0;
            slot_q     <= '0;
            word_q     <= '0;
            ovf_q      <= 1'b0;
        end else if (strobe) begin
            done_q     <= res_i;
            done_ovf_q <= left_i;
            tx_q       <= done_q;
            word_q     <= done_q[0];
            ovf_q      <= done_ovf_q;
            slot_q     <= CNTW'(1);
        end else if (slot_q < CNTW'(MAXHIT)) begin
            word_q <= tx_q[slot_q[SLW-1:0]];
            slot_q <= slot_q + CNTW'(1);
        end else begin
            word_q <= '0;
        end
    end

    assign word_o = word_q;
    assign ovf_o  = ovf_q;
endmodule

// File: rtl/strip_hit_encoder.sv
`timescale 1ns/1ps
module strip_hit_encoder
    import strip_enc_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       bx_strobe,
    input  logic [NSTRIP-1:0]          hit_in,
    input  logic [ZVECW-1:0]           z_in,
    output logic [WORDW-1:0]           word_o,
    output logic                       overflow_o
);
    hit_word_t res [MAXHIT];
    logic      left;
    hit_word_t word;

    sf_hit_scanner u_scan (
        .clk    (clk),
        .rst    (rst),
        .strobe (bx_strobe),
        .hit_in (hit_in),
        .z_in   (z_in),
        .res_o  (res),
        .left_o (left)
    );

    sf_slot_stream u_stream (
        .clk    (clk),
        .rst    (rst),
        .strobe (bx_strobe),
        .res_i  (res),
        .left_i (left),
        .word_o (word),
        .ovf_o  (overflow_o)
    );

    assign word_o = word;
endmodule

// File: rtl/strip_hit_encoder_chk.sv
`timescale 1ns/1ps
module strip_hit_encoder_chk
    import strip_enc_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             bx_strobe,
    input logic [WORDW-1:0] word_o,
    input logic             overflow_o
);
    logic rst_d;
    always_ff @(posedge clk) rst_d <= rst;

    // R5
    empty_payload_chk: assert property (@(posedge clk) disable iff (rst)
        !word_o[WORDW-1] |-> (word_o[WORDW-2:0] == '0));

    // R5
    invalid_tail_chk: assert property (@(posedge clk) disable iff (rst)
        (!word_o[WORDW-1] && !bx_strobe) |=> !word_o[WORDW-1]);

    // R3
    ascend_order_chk: assert property (@(posedge clk) disable iff (rst)
        (word_o[WORDW-1] && !bx_strobe) |=>
        (!word_o[WORDW-1] || (word_o[WORDW-2:ZW] > $past(word_o[WORDW-2:ZW]))));

    // R6
    ovf_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !bx_strobe |=> $stable(overflow_o));

    // R6
    ovf_full_chk: assert property (@(posedge clk) disable iff (rst)
        overflow_o |-> word_o[WORDW-1]);

    // R7
    always @(negedge clk) begin
        if (rst_d) begin
            reset_quiet_chk: assert (word_o == '0 && !overflow_o);
        end
    end
endmodule

bind strip_hit_encoder strip_hit_encoder_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .bx_strobe  (bx_strobe),
    .word_o     (word_o),
    .overflow_o (overflow_o)
);

// File: tb/test_strip_hit_encoder.sv
`timescale 1ns/1ps
module test_strip_hit_encoder;
    import strip_enc_pkg::*;

    localparam int MAXX = 128;
    localparam int NTAB = 12;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                bx_strobe = 1'b0;
    logic [NSTRIP-1:0]   hit_in = '0;
    logic [ZVECW-1:0]    z_in = '0;
    logic [WORDW-1:0]    word_o;
    logic                overflow_o;

    always #10 clk = ~clk;

    strip_hit_encoder i_strip_hit_encoder (
        .clk        (clk),
        .rst        (rst),
        .bx_strobe  (bx_strobe),
        .hit_in     (hit_in),
        .z_in       (z_in),
        .word_o     (word_o),
        .overflow_o (overflow_o)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;
    int xn = 0;

    logic [WORDW-1:0] exp_w   [MAXX][MAXHIT];
    logic             exp_ovf [MAXX];
    int               exp_cnt [MAXX];

    localparam logic [NSTRIP-1:0] HIT_TAB [NTAB] = '{
        128'h0,
        128'h1,
        128'h8000_0000_0000_0000_0000_0000_0000_0000,
        128'h8000_0100_0020_0004_0000_8000_1000_0201,
        128'h8000_0100_0020_0004_0000_8000_1000_0203,
        {128{1'b1}},
        128'hAAAA_AAAA_AAAA_AAAA_AAAA_AAAA_AAAA_AAAA,
        128'hF000_0000_0000_0000_0000_0000_0000_0000,
        128'h0000_0000_0000_0001_0000_0000_0000_0000,
        128'h000F_FFFF_0000_0000_0000_0000_0000_0000,
        128'h5555_5555_5555_5555_5555_5555_5555_5555,
        128'h0000_0000_0000_0000_0000_0000_0000_0080
    };

    function automatic logic [ZVECW-1:0] table_z(input int n);
        logic [ZVECW-1:0] z;
        for (int i = 0; i < NSTRIP; i++) z[i*ZW +: ZW] = ZW'((i * 11 + n * 5) % 32);
        return z;
    endfunction

    function automatic logic [ZVECW-1:0] rand_z();
        logic [ZVECW-1:0] z;
        for (int i = 0; i < NSTRIP; i++) z[i*ZW +: ZW] = ZW'($urandom);
        return z;
    endfunction

    function automatic logic [NSTRIP-1:0] rand_hits();
        logic [NSTRIP-1:0] h;
        int n;
        h = '0;
        n = $urandom_range(0, 20);
        for (int j = 0; j < n; j++) h[$urandom_range(0, NSTRIP - 1)] = 1'b1;
        return h;
    endfunction

    task automatic predict(input logic [NSTRIP-1:0] h, input logic [ZVECW-1:0] z, input int n);
        int c;
        c = 0;
        for (int k = 0; k < MAXHIT; k++) exp_w[n][k] = '0;
        for (int i = 0; i < NSTRIP; i++) begin
            if (h[i]) begin
                if (c < MAXHIT) exp_w[n][c] = {1'b1, SIW'(i), z[i*ZW +: ZW]};
                c++;
            end
        end
        exp_cnt[n] = c;
        exp_ovf[n] = (c > MAXHIT);
    endtask

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h (crossing %0d)", tag, act, expv, xn);
        end
    endtask

    // called at a falling edge; runs one crossing of eight cycles
    task automatic crossing(input logic [NSTRIP-1:0] h, input logic [ZVECW-1:0] z);
        logic [WORDW-1:0] ew;
        logic             eo;
        string            tag;
        hit_in    = h;
        z_in      = z;
        bx_strobe = 1'b1;
        predict(h, z, xn);
        for (int k = 0; k < MAXHIT; k++) begin
            @(posedge clk);
            @(negedge clk);
            bx_strobe = 1'b0;
            // R1: junk on the inputs outside the strobe cycle
            for (int j = 0; j < NSTRIP / 32; j++) hit_in[j*32 +: 32] = $urandom;
            z_in = rand_z();
            if (xn >= 2) begin
                ew = exp_w[xn-2][k];
                eo = exp_ovf[xn-2];
                tag = ew[WORDW-1] ? "R1 R2 R3 R4 word" : "R5 empty slot";
            end else begin
                ew = '0;
                eo = 1'b0;
                tag = "R7 post-reset word";
            end
            check(word_o == ew, tag, 32'(word_o), 32'(ew));
            if (xn >= 2 && (exp_cnt[xn-2] == MAXHIT || exp_cnt[xn-2] == MAXHIT + 1))
                check(overflow_o == eo, "R8 overflow boundary", 32'(overflow_o), 32'(eo));
            else
                check(overflow_o == eo, (xn >= 2) ? "R6 overflow" : "R7 overflow", 32'(overflow_o), 32'(eo));
        end
        xn++;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(word_o == '0, "R7 word in reset", 32'(word_o), 32'h0);
        check(overflow_o == 1'b0, "R7 overflow in reset", 32'(overflow_o), 32'h0);
        rst = 1'b0;
        xn  = 0;

        for (int t = 0; t < NTAB; t++) crossing(HIT_TAB[t], table_z(t));
        for (int t = 0; t < 40; t++) crossing(rand_hits(), rand_z());
        crossing('0, rand_z());
        crossing('0, rand_z());

        // reset in the middle of a busy stream
        crossing({128{1'b1}}, rand_z());
        crossing(HIT_TAB[4], rand_z());
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(word_o == '0, "R7 word after mid-run reset", 32'(word_o), 32'h0);
        check(overflow_o == 1'b0, "R7 overflow after mid-run reset", 32'(overflow_o), 32'h0);
        rst = 1'b0;
        xn  = 0;
        crossing(HIT_TAB[3], table_z(3));
        crossing(HIT_TAB[4], table_z(4));
        crossing({128{1'b1}}, table_z(7));
        crossing('0, table_z(8));
        crossing('0, table_z(9));

        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule